// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Encoder

This block produces the transmit envelope of a pulse-distance infrared remote-control frame. While a key is held, it sends one complete frame and then a short repeat code at a fixed cadence. The envelope is active high and gates an external carrier generator. All timing is counted in ticks of a 1 µs strobe, so the block runs from any system clock.

A full frame starts with a long leader mark and a shorter leader space. Thirty-two pulse-distance bits follow, and a short stop mark ends the frame. Each bit is a fixed short mark followed by a space, and the space length tells a 0 from a 1. The 32-bit payload is built from four bytes, each sent least significant bit first, in this order:

1. The custom code.
2. A second custom byte, which is either a copy of the custom code or its complement.
3. The data code.
4. The inverted data code.

The codes are captured on the tick where the frame starts from idle and are held until the key is released. A new frame or repeat code starts at a fixed interval while the key stays down. A repeat code is a leader mark, a short space and a stop mark.

Top module: `ir_frame_encoder`

## Requirements
- R1: A full frame opens with a leader mark of T_LEAD_MARK ticks (default 9000), followed by a space of T_LEAD_SPACE ticks (default 4500).
- R2: Each payload bit is a mark of T_BIT_MARK ticks (default 560). The space that follows is T_ZERO-T_BIT_MARK ticks for a 0 and T_ONE-T_BIT_MARK ticks for a 1 (defaults 1125 and 2250 total).
- R3: The 32 payload bits go out as word bit 0 first through bit 31. The word is {~data_code, data_code, second byte, custom_code}, so custom_code bit 0 is sent first.
- R4: The second byte is custom_code when custom_same is 1 and ~custom_code when it is 0.
- R5: A stop mark of T_BIT_MARK ticks ends every frame and every repeat code. busy is high from the first leader tick to the end of the stop mark, and it falls together with envelope.
- R6: A repeat code is a leader mark of T_LEAD_MARK ticks, a space of T_REP_SPACE ticks (default 2250) and a stop mark.
- R7: While the key stays held, successive transmissions start exactly T_PERIOD ticks apart (default 108000). The first transmission is a full frame and every later one is a repeat code.
- R8: custom_code, data_code and custom_same are sampled only on the tick where a frame starts from idle. Changing them while the key is held has no effect.
- R9: If the key is released during a frame or a repeat code, that transmission completes and nothing further is sent.
- R10: After reset, and whenever no key has been pressed, envelope and busy are low.
- R11: envelope and busy change only on clock edges where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe marking each 1 µs time unit |
| key_held | input | 1 | High while a key is pressed |
| custom_code | input | 8 | Custom code byte |
| data_code | input | 8 | Data code byte |
| custom_same | input | 1 | 1: second byte copies the custom code; 0: second byte is its complement |
| envelope | output | 1 | High while the carrier should be on |
| busy | output | 1 | High from leader start to stop-mark end |

## Verification
The hardest situations to reach are the release timings. One is a key that drops in the middle of a full frame. Another is a key that drops while a repeat code is in flight. A third is a key that drops in the silent gap between transmissions. Each of these must end the burst differently, with nothing sent afterwards. The stimulus times each release as a fixed number of ticks after the press, chosen from the scaled segment lengths, so that it lands inside the intended interval. It also changes the code inputs while a held key is still repeating.

// File: rtl/ir_frame_encoder.sv
module ir_frame_encoder #(
  parameter int T_LEAD_MARK  = 9000,
  parameter int T_LEAD_SPACE = 4500,
  parameter int T_BIT_MARK   = 560,
  parameter int T_ZERO       = 1125,
  parameter int T_ONE        = 2250,
  parameter int T_REP_SPACE  = 2250,
  parameter int T_PERIOD     = 108000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       key_held,
  input  logic [7:0] custom_code,
  input  logic [7:0] data_code,
  input  logic       custom_same,
  output logic       envelope,
  output logic       busy
);
  localparam int SEG_MAX = (T_LEAD_MARK > T_ONE) ? T_LEAD_MARK : T_ONE;
  localparam int CW = $clog2(SEG_MAX + 1);
  localparam int SW = $clog2(T_PERIOD + 1);

  typedef enum logic [2:0] {IDLE, HMARK, HSPACE, BMARK, BSPACE, STOP, WAIT} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  seg_len;
  logic [SW-1:0]  slot;
  logic [31:0]    word;
  logic [4:0]     bidx;
  logic           rpt;
  logic           released;
  logic           seg_done;

  always_comb begin
    case (st)
      HMARK:   seg_len = CW'(T_LEAD_MARK);
      HSPACE:  seg_len = rpt ? CW'(T_REP_SPACE) : CW'(T_LEAD_SPACE);
      BMARK:   seg_len = CW'(T_BIT_MARK);
      BSPACE:  seg_len = word[bidx] ? CW'(T_ONE - T_BIT_MARK) : CW'(T_ZERO - T_BIT_MARK);
      STOP:    seg_len = CW'(T_BIT_MARK);
      default: seg_len = '0;
    endcase
  end

  assign seg_done = tick && (cnt == seg_len - CW'(1));
  assign envelope = (st == HMARK) || (st == BMARK) || (st == STOP);
  assign busy     = (st != IDLE) && (st != WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      slot     <= '0;
      word     <= '0;
      bidx     <= '0;
      rpt      <= 1'b0;
      released <= 1'b0;
    end else begin
      if (st != IDLE && !key_held) released <= 1'b1;
      if (tick && st != IDLE) begin
        slot <= slot + SW'(1);
        cnt  <= seg_done ? '0 : cnt + CW'(1);
      end
      case (st)
        IDLE:
          if (tick && key_held) begin
            st       <= HMARK;
            cnt      <= '0;
            slot     <= '0;
            rpt      <= 1'b0;
            released <= 1'b0;
            word     <= {~data_code, data_code,
                         custom_same ? custom_code : ~custom_code, custom_code};
          end
        HMARK:  if (seg_done) st <= HSPACE;
        HSPACE:
          if (seg_done) begin
            st   <= rpt ? STOP : BMARK;
            bidx <= '0;
          end
        BMARK:  if (seg_done) st <= BSPACE;
        BSPACE:
          if (seg_done) begin
            st   <= (bidx == 5'd31) ? STOP : BMARK;
            bidx <= bidx + 5'd1;
          end
        STOP:
          if (seg_done) st <= (released || !key_held) ? IDLE : WAIT;
        WAIT:
          if (released || !key_held) st <= IDLE;
          else if (tick && slot == SW'(T_PERIOD - 1)) begin
            st   <= HMARK;
            cnt  <= '0;
            slot <= '0;
            rpt  <= 1'b1;
          end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ir_frame_encoder_chk.sv
module ir_frame_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        key_held,
  input logic        envelope,
  input logic        busy,
  input logic [31:0] word
);
  AST_ENV_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    envelope |-> busy); // R5
  AST_BUSY_ENDS_WITH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(envelope)); // R5
  AST_START_WITH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> envelope); // R1
  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key_held)); // R9
  AST_ENV_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(envelope) && $stable(busy)); // R11
  AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(word)); // R8
endmodule

bind ir_frame_encoder ir_frame_encoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .key_held(key_held),
  .envelope(envelope), .busy(busy), .word(word)
);

// File: tb/ir_frame_encoder_test.sv
module ir_frame_encoder_test;
  localparam int LM = 36, LS = 18, BM = 4, ZR = 8, ON = 16, RS = 9, PER = 600;

  logic clk = 0, rst_n = 0, tick = 0, key_held = 0, custom_same = 0;
  logic [7:0] custom_code = 0, data_code = 0;
  logic envelope, busy;
  int total = 0, bad = 0;

  ir_frame_encoder #(.T_LEAD_MARK(LM), .T_LEAD_SPACE(LS), .T_BIT_MARK(BM),
    .T_ZERO(ZR), .T_ONE(ON), .T_REP_SPACE(RS), .T_PERIOD(PER)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_held(key_held),
    .custom_code(custom_code), .data_code(data_code), .custom_same(custom_same),
    .envelope(envelope), .busy(busy));

  always #2 clk = ~clk;
  always @(negedge clk) if (rst_n) tick <= ~tick;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: queue of per-tick envelope levels
  bit q[$];
  bit m_env = 0, m_busy = 0, m_sess = 0, m_rel = 0;
  int m_slot = 0;

  task automatic push_n(input bit v, input int n);
    for (int i = 0; i < n; i++) q.push_back(v);
  endtask

  always @(posedge clk) if (rst_n) begin
    if (m_sess && !key_held) m_rel = 1;
    if (tick) begin
      if (m_sess) m_slot++;
      if (m_sess && m_rel && q.size() == 0) m_sess = 0;
      if (!m_sess && key_held) begin
        logic [31:0] w;
        w = {~data_code, data_code, custom_same ? custom_code : ~custom_code, custom_code};
        push_n(1, LM); push_n(0, LS);
        for (int i = 0; i < 32; i++) begin
          push_n(1, BM); push_n(0, w[i] ? ON - BM : ZR - BM);
        end
        push_n(1, BM);
        m_sess = 1; m_rel = 0; m_slot = 0;
      end else if (m_sess && !m_rel && q.size() == 0 && m_slot == PER) begin
        push_n(1, LM); push_n(0, RS); push_n(1, BM);
        m_slot = 0;
      end
      if (q.size() > 0) begin m_env = q.pop_front(); m_busy = 1; end
      else begin m_env = 0; m_busy = 0; end
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(envelope === m_env, "R11 envelope vs model", envelope, m_env);
    check(busy === m_busy, "R5 busy vs model", busy, m_busy);
  end

  // envelope run-length decoder and start-time log
  bit seg_lv[$];
  int seg_len[$];
  int starts[$];
  bit cur_lv = 0, busy_d = 0;
  int run = 0, tcount = 0;

  always @(posedge clk) if (rst_n && tick) begin
    tcount++;
    if (envelope == cur_lv) run++;
    else begin
      seg_lv.push_back(cur_lv); seg_len.push_back(run);
      cur_lv = envelope; run = 1;
    end
  end

  always @(negedge clk) begin
    if (busy && !busy_d) starts.push_back(tcount);
    busy_d = busy;
  end

  task automatic pop_seg(output bit lv, output int len);
    if (seg_lv.size() == 0) begin lv = 0; len = -1; end
    else begin lv = seg_lv.pop_front(); len = seg_len.pop_front(); end
  endtask

  // kind: 0 none, 1 full frame, 2 repeat, -1 malformed
  task automatic take_frame(output int kind, output logic [31:0] w);
    bit lv; int len;
    w = '0;
    pop_seg(lv, len);
    while (lv == 0 && len != -1) pop_seg(lv, len);
    if (len == -1) begin kind = 0; return; end
    if (len != LM) begin kind = -1; return; end
    pop_seg(lv, len);
    if (len == RS) begin
      pop_seg(lv, len);
      kind = (lv == 1 && len == BM) ? 2 : -1;
      return;
    end
    if (len != LS) begin kind = -1; return; end
    kind = 1;
    for (int i = 0; i < 32; i++) begin
      pop_seg(lv, len);
      if (lv != 1 || len != BM) kind = -1;
      pop_seg(lv, len);
      if (len == ZR - BM) w[i] = 1'b0;
      else if (len == ON - BM) w[i] = 1'b1;
      else kind = -1;
    end
    pop_seg(lv, len);
    if (lv != 1 || len != BM) kind = -1;
  endtask

  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic clear_logs();
    seg_lv.delete(); seg_len.delete(); starts.delete();
  endtask

  initial begin
    int kind;
    logic [31:0] w;
    repeat (5) @(negedge clk);
    check(envelope === 1'b0 && busy === 1'b0, "R10 reset state", {envelope, busy}, 0);
    rst_n = 1;
    wait_ticks(20);
    check(envelope === 1'b0 && busy === 1'b0, "R10 idle without key", {envelope, busy}, 0);

    // held key: full frame, two repeats, codes changed mid-hold
    clear_logs();
    custom_code = 8'hA5; data_code = 8'h3C; custom_same = 0;
    key_held = 1;
    wait_ticks(100);
    custom_code = 8'h00; data_code = 8'hFF; custom_same = 1;
    wait_ticks(1400);
    key_held = 0;
    wait_ticks(800);
    check(starts.size() == 3, "R7 transmissions while held", starts.size(), 3);
    if (starts.size() == 3) begin
      check(starts[1] - starts[0] == PER, "R7 cadence first", starts[1] - starts[0], PER);
      check(starts[2] - starts[1] == PER, "R7 cadence second", starts[2] - starts[1], PER);
    end
    take_frame(kind, w);
    check(kind == 1, "R1 R2 full frame shape", kind, 1);
    check(w == 32'hC33C5AA5, "R3 R4 R8 payload complement", w, 32'hC33C5AA5);
    take_frame(kind, w);
    check(kind == 2, "R6 first repeat", kind, 2);
    take_frame(kind, w);
    check(kind == 2, "R6 second repeat", kind, 2);
    take_frame(kind, w);
    check(kind == 0, "R9 nothing after release in gap", kind, 0);

    // release in mid-frame, copied second byte
    clear_logs();
    custom_code = 8'hFF; data_code = 8'h00; custom_same = 1;
    key_held = 1;
    wait_ticks(100);
    key_held = 0;
    wait_ticks(1500);
    check(starts.size() == 1, "R9 single frame on short press", starts.size(), 1);
    take_frame(kind, w);
    check(kind == 1, "R5 frame completes with stop", kind, 1);
    check(w == 32'hFF00FFFF, "R4 second byte copy", w, 32'hFF00FFFF);
    take_frame(kind, w);
    check(kind == 0, "R9 no repeat after mid-frame release", kind, 0);

    // release during the first repeat code
    clear_logs();
    custom_code = 8'h12; data_code = 8'h81; custom_same = 0;
    key_held = 1;
    wait_ticks(620);
    key_held = 0;
    wait_ticks(1500);
    check(starts.size() == 2, "R9 repeat finished then stop", starts.size(), 2);
    take_frame(kind, w);
    check(kind == 1 && w == 32'h7E81ED12, "R3 frame word", w, 32'h7E81ED12);
    take_frame(kind, w);
    check(kind == 2, "R6 repeat completes after release", kind, 2);
    take_frame(kind, w);
    check(kind == 0, "R9 nothing after repeat", kind, 0);
    check(envelope === 1'b0 && busy === 1'b0, "R10 idle at end", {envelope, busy}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule